// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Wakeup

This block holds instructions that are waiting to run on one class of execution unit. An instruction enters a free slot through the issue port with an opcode and two source operands. Each operand arrives either as a ready value (tag zero) or as the nonzero tag of the slot that will produce it. The bank returns the tag of the slot it allocates, so the renaming logic upstream can point later consumers at it. When no slot is free, the bank raises a full flag and the issue stage must hold the instruction.

Every cycle the bank watches the result bus. A slot with a pending operand takes the broadcast value when the broadcast tag equals that operand's tag. One broadcast can fill operands in any number of slots at once. A slot becomes ready once both operands are values. Of the ready slots, the lowest-index one that has not yet been sent is offered on the dispatch port. A slot stays occupied after dispatch and is freed only when its own tag appears on the result bus.

Slot i carries tag BASE_TAG+i. Tags are 4 bits wide. The value 0 is reserved for "operand holds a value".

Top module: `rsb_bank`

## Requirements
- R1: After reset, `bank_full` is 0 and `disp_valid` is 0.
- R2: An issue (`iss_valid` while `bank_full` is 0) goes into the lowest-index free slot. `iss_tag` always shows BASE_TAG plus the index of that slot. `bank_full` is 1 exactly when every slot is occupied. An issue made while full changes nothing.
- R3: A source tag of 0 means the matching value input is the operand. An instruction issued with both tags 0 can be offered on the dispatch port on the next cycle, with the values it was given.
- R4: A slot with a nonzero source tag on either operand is not offered for dispatch until a broadcast carries that tag. It then takes `cdb_value` as that operand.
- R5: A single broadcast fills the matching operand in every waiting slot in the same cycle. All slots that become complete are ready on the next cycle.
- R6: If a broadcast carries a source tag in the same cycle that the source is issued, the slot records the broadcast value and the operand counts as present.
- R7: The dispatch port offers the lowest-index ready slot that has not been dispatched. A slot counts as dispatched in a cycle where `disp_valid` and `disp_ready` are both 1. After that it is never offered again until it has been freed and issued anew. While `disp_ready` is 0, the offer holds.
- R8: A slot stays occupied from issue until a broadcast carries its own tag. Dispatch alone does not free it.
- R9: A broadcast whose tag matches no pending operand changes no slot's readiness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of issued instruction |
| iss_j_tag | input | 4 | Producer tag of first operand, 0 = value given |
| iss_j_val | input | DATA_W | First operand value |
| iss_k_tag | input | 4 | Producer tag of second operand, 0 = value given |
| iss_k_val | input | DATA_W | Second operand value |
| iss_tag | output | 4 | Tag of the slot the next issue will use |
| bank_full | output | 1 | All slots occupied; issue must stall |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Tag of the broadcasting producer |
| cdb_value | input | DATA_W | Broadcast result |
| disp_valid | output | 1 | A ready slot is offered |
| disp_ready | input | 1 | Execution unit accepts the offer |
| disp_op | output | OP_W | Opcode of offered slot |
| disp_j | output | DATA_W | First operand of offered slot |
| disp_k | output | DATA_W | Second operand of offered slot |
| disp_tag | output | 4 | Tag of offered slot |

## Verification
The bench fills all four slots with operands that wait on one common external tag. It checks that one broadcast releases all of them together and that they then leave strictly in index order. A design that matched only one slot per broadcast would dispatch just one. A design that did not mark slots as dispatched would offer the same tag again. It broadcasts on the exact cycle of issue and expects the value to be kept. Without that bypass, the slot would wait forever for a tag that has already gone by. It also checks that dispatch does not free a slot and that an unrelated tag wakes nothing. It makes a later slot ready before an earlier one, so a selector with fixed arrival order or the wrong priority is exposed. It tries an issue while the bank is full, to catch a design that overwrites an occupied slot.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int RSB_TAG_W = 4;
  typedef logic [RSB_TAG_W-1:0] rsb_tag_t;

  // A pending operand (nonzero tag) captured by a live broadcast of that tag.
  function automatic logic tag_hit(input logic bus_v, input rsb_tag_t bus_tag,
                                   input rsb_tag_t want);
    return bus_v && (want != '0) && (bus_tag == want);
  endfunction
endpackage

// File: rtl/rsb_pick.sv
module rsb_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rsb_slot.sv
module rsb_slot
  import rsb_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter int          OP_W   = 4,
  parameter int unsigned MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OP_W-1:0]   wr_op,
  input  rsb_tag_t          wr_jt,
  input  logic [DATA_W-1:0] wr_jv,
  input  rsb_tag_t          wr_kt,
  input  logic [DATA_W-1:0] wr_kv,
  input  logic              bus_v,
  input  rsb_tag_t          bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  input  logic              take,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] jv,
  output logic [DATA_W-1:0] kv
);
  localparam rsb_tag_t SELF = RSB_TAG_W'(MY_TAG);

  logic              busy_q, busy_d, done_q, done_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [DATA_W-1:0] jv_q, jv_d, kv_q, kv_d;
  rsb_tag_t          jt_q, jt_d, kt_q, kt_d;
  logic              data_en;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    op_d   = op_q;
    jv_d   = jv_q;
    kv_d   = kv_q;
    jt_d   = jt_q;
    kt_d   = kt_q;
    if (wr_en) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      op_d   = wr_op;
      if (tag_hit(bus_v, bus_tag, wr_jt)) begin
        jt_d = '0;
        jv_d = bus_val;
      end else begin
        jt_d = wr_jt;
        jv_d = wr_jv;
      end
      if (tag_hit(bus_v, bus_tag, wr_kt)) begin
        kt_d = '0;
        kv_d = bus_val;
      end else begin
        kt_d = wr_kt;
        kv_d = wr_kv;
      end
    end else if (busy_q) begin
      if (tag_hit(bus_v, bus_tag, jt_q)) begin
        jt_d = '0;
        jv_d = bus_val;
      end
      if (tag_hit(bus_v, bus_tag, kt_q)) begin
        kt_d = '0;
        kv_d = bus_val;
      end
      if (take) done_d = 1'b1;
      if (bus_v && bus_tag == SELF) begin
        busy_d = 1'b0;
        done_d = 1'b0;
      end
    end
  end

  assign data_en = wr_en | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      jt_q   <= '0;
      kt_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (data_en) begin
        jt_q <= jt_d;
        kt_q <= kt_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      op_q <= op_d;
      jv_q <= jv_d;
      kv_q <= kv_d;
    end
  end

  assign busy  = busy_q;
  assign ready = busy_q && !done_q && (jt_q == '0) && (kt_q == '0);
  assign op    = op_q;
  assign jv    = jv_q;
  assign kv    = kv_q;
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank
  import rsb_pkg::*;
#(
  parameter int N        = 4,
  parameter int DATA_W   = 16,
  parameter int OP_W     = 4,
  parameter int BASE_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [3:0]        iss_j_tag,
  input  logic [DATA_W-1:0] iss_j_val,
  input  logic [3:0]        iss_k_tag,
  input  logic [DATA_W-1:0] iss_k_val,
  output logic [3:0]        iss_tag,
  output logic              bank_full,
  input  logic              cdb_valid,
  input  logic [3:0]        cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_j,
  output logic [DATA_W-1:0] disp_k,
  output logic [3:0]        disp_tag
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      busy_vec, ready_vec, free_req;
  logic              free_hit, iss_go;
  logic [IDX_W-1:0]  free_idx, disp_idx;
  logic [OP_W-1:0]   op_a [N];
  logic [DATA_W-1:0] jv_a [N];
  logic [DATA_W-1:0] kv_a [N];

  assign free_req = ~busy_vec;

  rsb_pick #(.N(N), .IDX_W(IDX_W)) u_free_pick (
    .req(free_req), .hit(free_hit), .idx(free_idx)
  );

  rsb_pick #(.N(N), .IDX_W(IDX_W)) u_disp_pick (
    .req(ready_vec), .hit(disp_valid), .idx(disp_idx)
  );

  assign iss_go = iss_valid && free_hit;

  for (genvar g = 0; g < N; g++) begin : g_slot
    rsb_slot #(
      .DATA_W(DATA_W), .OP_W(OP_W), .MY_TAG(BASE_TAG + g)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (iss_go && (free_idx == IDX_W'(g))),
      .wr_op  (iss_op),
      .wr_jt  (iss_j_tag),
      .wr_jv  (iss_j_val),
      .wr_kt  (iss_k_tag),
      .wr_kv  (iss_k_val),
      .bus_v  (cdb_valid),
      .bus_tag(cdb_tag),
      .bus_val(cdb_value),
      .take   (disp_valid && disp_ready && (disp_idx == IDX_W'(g))),
      .busy   (busy_vec[g]),
      .ready  (ready_vec[g]),
      .op     (op_a[g]),
      .jv     (jv_a[g]),
      .kv     (kv_a[g])
    );
  end

  assign bank_full = !free_hit;
  assign iss_tag   = RSB_TAG_W'(BASE_TAG) + RSB_TAG_W'(free_idx);
  assign disp_tag  = RSB_TAG_W'(BASE_TAG) + RSB_TAG_W'(disp_idx);
  assign disp_op   = op_a[disp_idx];
  assign disp_j    = jv_a[disp_idx];
  assign disp_k    = kv_a[disp_idx];
endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk #(
  parameter int N = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       iss_valid,
  input logic [3:0] iss_j_tag,
  input logic [3:0] iss_k_tag,
  input logic [3:0] iss_tag,
  input logic       bank_full,
  input logic       cdb_valid,
  input logic [3:0] cdb_tag,
  input logic       disp_valid,
  input logic       disp_ready,
  input logic [3:0] disp_tag,
  input logic [N-1:0] busy_vec
);
  // R2
  fill_to_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !bank_full && $countones(busy_vec) == N - 1) |=> bank_full);

  // R8
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_full && !cdb_valid) |=> bank_full);

  // R7
  no_redispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> !(disp_valid && disp_tag == $past(disp_tag)));

  // R3
  ready_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !bank_full && iss_j_tag == 4'd0 && iss_k_tag == 4'd0 && !disp_valid)
    |=> disp_valid);

  // R4
  pending_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !bank_full &&
     ((iss_j_tag != 4'd0 && !(cdb_valid && cdb_tag == iss_j_tag)) ||
      (iss_k_tag != 4'd0 && !(cdb_valid && cdb_tag == iss_k_tag))))
    |=> !(disp_valid && disp_tag == $past(iss_tag)));
endmodule

bind rsb_bank rsb_bank_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_j_tag(iss_j_tag),
  .iss_k_tag(iss_k_tag), .iss_tag(iss_tag), .bank_full(bank_full),
  .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .disp_tag(disp_tag), .busy_vec(busy_vec)
);

// File: tb/sim_rsb_bank.sv
module sim_rsb_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, cdb_valid, disp_ready;
  logic [3:0]  iss_op, iss_j_tag, iss_k_tag, cdb_tag;
  logic [15:0] iss_j_val, iss_k_val, cdb_value;
  logic [3:0]  iss_tag, disp_op, disp_tag;
  logic        bank_full, disp_valid;
  logic [15:0] disp_j, disp_k;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rsb_bank u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_j_tag(iss_j_tag), .iss_j_val(iss_j_val), .iss_k_tag(iss_k_tag),
    .iss_k_val(iss_k_val), .iss_tag(iss_tag), .bank_full(bank_full),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_j(disp_j), .disp_k(disp_k), .disp_tag(disp_tag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance to next negedge, inputs applied by caller, then settle
  task automatic cyc();
    @(negedge clk);
    iss_valid = 0; cdb_valid = 0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic issue(input int op, input int jt, input int jv, input int kt, input int kv);
    iss_valid = 1; iss_op = 4'(op);
    iss_j_tag = 4'(jt); iss_j_val = 16'(jv);
    iss_k_tag = 4'(kt); iss_k_val = 16'(kv);
  endtask

  task automatic bcast(input int t, input int v);
    cdb_valid = 1; cdb_tag = 4'(t); cdb_value = 16'(v);
  endtask

  task automatic test_reset();
    settle();
    chk("R1 full", int'(bank_full), 0);
    chk("R1 disp_valid", int'(disp_valid), 0);
  endtask

  task automatic test_basic();
    disp_ready = 0;
    cyc(); issue(1, 0, 'h11, 0, 'h22); settle();
    chk("R2 tag slot0", int'(iss_tag), 1);
    cyc(); issue(2, 0, 'h33, 0, 'h44); settle();
    chk("R2 tag slot1", int'(iss_tag), 2);
    chk("R3 valid", int'(disp_valid), 1);
    chk("R3 tag", int'(disp_tag), 1);
    chk("R3 j", int'(disp_j), 'h11);
    chk("R3 k", int'(disp_k), 'h22);
    chk("R3 op", int'(disp_op), 1);
    cyc(); disp_ready = 1; settle();
    chk("R7 first", int'(disp_tag), 1);
    cyc(); settle();
    chk("R7 second", int'(disp_tag), 2);
    chk("R7 second op", int'(disp_op), 2);
    cyc(); disp_ready = 0; settle();
    chk("R7 once", int'(disp_valid), 0);
    chk("R8 dispatch keeps busy", int'(iss_tag), 3);
    cyc(); bcast(2, 0); settle();
    cyc(); settle();
    chk("R8 own tag frees", int'(iss_tag), 2);
    cyc(); bcast(1, 0); settle();
    cyc(); settle();
    chk("R8 all free", int'(iss_tag), 1);
    chk("R8 not full", int'(bank_full), 0);
  endtask

  task automatic test_full_wake();
    for (int i = 0; i < 4; i++) begin
      cyc(); issue(3 + i, 9, 0, 0, i); settle();
      chk("R2 alloc order", int'(iss_tag), i + 1);
    end
    cyc(); issue('hF, 0, 'hEE, 0, 'hEE); settle();
    chk("R2 full", int'(bank_full), 1);
    cyc(); bcast(10, 'hAA); settle();
    chk("R4 waits", int'(disp_valid), 0);
    cyc(); bcast(9, 'h55); settle();
    chk("R9 unrelated", int'(disp_valid), 0);
    cyc(); disp_ready = 1; settle();
    chk("R5 woke", int'(disp_valid), 1);
    for (int i = 0; i < 4; i++) begin
      if (i > 0) begin cyc(); settle(); end
      chk("R5 tag", int'(disp_tag), i + 1);
      chk("R5 j", int'(disp_j), 'h55);
      chk("R5 k", int'(disp_k), i);
      chk("R2 op kept", int'(disp_op), 3 + i);
    end
    cyc(); disp_ready = 0; settle();
    chk("R2 ignored issue", int'(disp_valid), 0);
    chk("R8 still full", int'(bank_full), 1);
    for (int t = 1; t <= 4; t++) begin
      cyc(); bcast(t, 0);
    end
    cyc(); settle();
    chk("R8 freed", int'(bank_full), 0);
    chk("R8 tag back", int'(iss_tag), 1);
  endtask

  task automatic test_bypass();
    disp_ready = 0;
    cyc(); issue(7, 11, 0, 0, 5); bcast(11, 'h77); settle();
    chk("R6 tag", int'(iss_tag), 1);
    cyc(); issue(8, 0, 1, 12, 0); bcast(12, 'h99); settle();
    chk("R6 j ready", int'(disp_valid), 1);
    chk("R6 j value", int'(disp_j), 'h77);
    chk("R6 k given", int'(disp_k), 5);
    cyc(); disp_ready = 1; settle();
    chk("R6 first", int'(disp_tag), 1);
    cyc(); settle();
    chk("R6 k tag", int'(disp_tag), 2);
    chk("R6 k value", int'(disp_k), 'h99);
    cyc(); disp_ready = 0; bcast(1, 0);
    cyc(); bcast(2, 0);
    cyc(); settle();
    chk("R8 bypass freed", int'(iss_tag), 1);
  endtask

  task automatic test_priority();
    disp_ready = 0;
    cyc(); issue(9, 0, 1, 13, 0);
    cyc(); issue(10, 0, 2, 0, 3);
    cyc(); settle();
    chk("R7 later ready", int'(disp_tag), 2);
    cyc(); bcast(13, 'h3C); settle();
    chk("R4 k pending", int'(disp_tag), 2);
    cyc(); disp_ready = 1; settle();
    chk("R7 lowest", int'(disp_tag), 1);
    chk("R4 k value", int'(disp_k), 'h3C);
    cyc(); settle();
    chk("R7 next", int'(disp_tag), 2);
    cyc(); disp_ready = 0; settle();
    chk("R7 drained", int'(disp_valid), 0);
    cyc(); bcast(1, 0);
    cyc(); bcast(2, 0);
    cyc(); settle();
    chk("R8 end", int'(bank_full), 0);
  endtask

  initial begin
    rst_n = 0; iss_valid = 0; cdb_valid = 0; disp_ready = 0;
    iss_op = 0; iss_j_tag = 0; iss_k_tag = 0; iss_j_val = 0; iss_k_val = 0;
    cdb_tag = 0; cdb_value = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    test_reset();
    test_basic();
    test_full_wake();
    test_bypass();
    test_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule